// File: doc/BRIEF.md
# Sync and Flag Detect Indicator

This block watches a serial receive stream, one bit per bit-clock enable, and compares the newest bits against a match target. In character-oriented operation the target is a programmable sync character of 8 or 6 bits; in bit-oriented operation it is the fixed frame flag 0x7E. A match drives an active-low detect pin one bit time later, for one bit time, and the first match while hunting establishes character framing. From then on a one-clock character-boundary strobe marks every N-th bit until hunting resumes.

In character-oriented operation framing can also be forced from outside: holding the active-low external sync input low at a bit clock while hunting locks framing at that bit without any sync character on the line. The detect pin can be given over to a request-to-send function instead, in which case it carries the inverted request level and hides detection. Assembly of characters after framing is left to the next stage.

Top module: `sync_flag_detect`

## Requirements
- R1: After reset, sync_det_n is high, char_strobe is low and locked is low.
- R2: With mode_bop low, a match occurs at a bit clock when the last N received bits equal the sync character, where N is 8 (sync_short low) or 6 (sync_short high). The oldest of the N bits is compared with sync_char[N-1] and the newest with sync_char[0]. With 6-bit length, sync_char[7:6] is ignored.
- R3: With mode_bop high, the target is 0x7E (received as 0,1,1,1,1,1,1,0), the length is 8, and sync_char is ignored.
- R4: With pin_as_rts low, sync_det_n goes low at the first bit clock after the bit that completes a match and stays low for exactly one bit time. It changes only on bit clocks.
- R5: No match is recognised until at least N bits have been received since rx_enable last rose or since reset.
- R6: While unlocked, the first match sets locked at the bit clock of the matching bit. While locked, char_strobe pulses high for one clock after every N-th following bit clock. Later matches do not move the boundary.
- R7: With mode_bop low and the block unlocked, ext_sync_n low at a bit clock sets locked at that bit, with strobes following as in R6, and gives no detect pulse. With mode_bop high, ext_sync_n is ignored.
- R8: A one-clock hunt pulse clears locked and stops strobes; the next match or external sync locks again.
- R9: rx_enable low clears locked, the received bit history and any pending or active detect.
- R10: With pin_as_rts high, sync_det_n equals the inverse of rts_req and detection does not appear on it. Framing continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable; low clears state |
| bit_en | input | 1 | One-clock pulse per received bit |
| rx_bit | input | 1 | Serial receive data, sampled with bit_en |
| mode_bop | input | 1 | 1 = bit-oriented (flag target), 0 = character-oriented |
| sync_short | input | 1 | 1 = 6-bit sync character, 0 = 8-bit |
| sync_char | input | 8 | Programmable sync character |
| ext_sync_n | input | 1 | Active-low external framing input |
| hunt | input | 1 | One-clock command to re-enter hunt |
| pin_as_rts | input | 1 | 1 = detect pin carries request-to-send |
| rts_req | input | 1 | Request-to-send level when pin_as_rts is high |
| sync_det_n | output | 1 | Active-low sync/flag detect or request-to-send pin |
| char_strobe | output | 1 | One-clock character boundary pulse |
| locked | output | 1 | Character framing established |

## Verification
The bench sends streams where a partial window padded with cleared history would fake a flag, so a design without the fill guard pulses detect early. Back-to-back flags sharing a zero must give two pulses exactly seven bits apart, which a detector that stretches or merges pulses gets wrong. Strobe spacing is measured for both 8 and 6 bit lengths, catching an off-by-one counter, and the external sync, hunt and disable paths are driven so that an ignored command, a leftover pending pulse or external sync honoured in bit-oriented mode each show at the pins.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   localparam int unsigned SFD_MAX_W = 8;
   localparam logic [SFD_MAX_W-1:0] SFD_FLAG = 8'h7E;

   function automatic int unsigned sfd_cnt_w(input int unsigned w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/sfd_shift.sv
module sfd_shift #(
   parameter int unsigned W  = 8,
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_rx,
   input  logic          bit_en,
   input  logic          rx_bit,
   output logic [W-1:0]  win_nxt,
   output logic [CW-1:0] fill_nxt
);
   logic [W-1:0]  win_q;
   logic [CW-1:0] fill_q;

   // Window as it will be once the current bit is taken in.
   always_comb begin
      win_nxt  = {win_q[W-2:0], rx_bit};
      fill_nxt = (fill_q == CW'(W)) ? fill_q : fill_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (!en_rx) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (bit_en) begin
         win_q  <= win_nxt;
         fill_q <= fill_nxt;
      end
   end
endmodule

// File: rtl/sfd_match.sv
module sfd_match #(
   parameter int unsigned W       = 8,
   parameter int unsigned SHORT_W = 6,
   parameter int unsigned CW      = 4,
   parameter logic [W-1:0] FLAG   = 8'h7E
) (
   input  logic [W-1:0]  win,
   input  logic [CW-1:0] fill,
   input  logic [CW-1:0] len,
   input  logic          bop,
   input  logic          short_sel,
   input  logic [W-1:0]  pattern,
   output logic          hit
);
   logic [W-1:0] tgt;
   logic [W-1:0] eq;
   logic         short_on;

   always_comb begin
      tgt      = bop ? FLAG : pattern;
      short_on = short_sel && !bop;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < SHORT_W) begin : g_core
         assign eq[i] = (win[i] == tgt[i]);
      end else begin : g_ext
         assign eq[i] = (win[i] == tgt[i]) || short_on;
      end
   end

   assign hit = (&eq) && (fill >= len);
endmodule

// File: rtl/sfd_frame.sv
module sfd_frame #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_rx,
   input  logic          hunt,
   input  logic          bit_en,
   input  logic          start,
   input  logic [CW-1:0] len,
   output logic          locked,
   output logic          strobe
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         cnt_q  <= '0;
         strobe <= 1'b0;
      end else if (!en_rx || hunt) begin
         locked <= 1'b0;
         cnt_q  <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         if (bit_en) begin
            if (!locked) begin
               if (start) begin
                  locked <= 1'b1;
                  cnt_q  <= '0;
               end
            end else if (cnt_q == len - 1'b1) begin
               cnt_q  <= '0;
               strobe <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sfd_detect.sv
module sfd_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic en_rx,
   input  logic bit_en,
   input  logic hit,
   input  logic pin_as_rts,
   input  logic rts_req,
   output logic det_n
);
   logic pend_q;
   logic det_q;

   // pend_q marks the matching bit; det_q shows it one bit later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         det_q  <= 1'b0;
      end else if (!en_rx) begin
         pend_q <= 1'b0;
         det_q  <= 1'b0;
      end else if (bit_en) begin
         pend_q <= hit;
         det_q  <= pend_q;
      end
   end

   assign det_n = pin_as_rts ? !rts_req : !det_q;
endmodule

// File: rtl/sync_flag_detect.sv
module sync_flag_detect
   import sfd_pkg::*;
#(
   parameter int unsigned W       = SFD_MAX_W,
   parameter int unsigned SHORT_W = 6,
   parameter logic [W-1:0] FLAG   = SFD_FLAG,
   localparam int unsigned CW     = sfd_cnt_w(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_enable,
   input  logic         bit_en,
   input  logic         rx_bit,
   input  logic         mode_bop,
   input  logic         sync_short,
   input  logic [W-1:0] sync_char,
   input  logic         ext_sync_n,
   input  logic         hunt,
   input  logic         pin_as_rts,
   input  logic         rts_req,
   output logic         sync_det_n,
   output logic         char_strobe,
   output logic         locked
);
   initial begin : elab_checks
      assert (SHORT_W >= 2 && SHORT_W < W)
         else $error("SHORT_W must lie between 2 and W-1");
      assert (W <= SFD_MAX_W)
         else $error("W exceeds the supported window");
   end

   logic [W-1:0]  win_nxt;
   logic [CW-1:0] fill_nxt;
   logic [CW-1:0] len;
   logic          raw_hit;
   logic          hit;
   logic          ext_ok;

   assign len    = (!mode_bop && sync_short) ? CW'(SHORT_W) : CW'(W);
   assign hit    = raw_hit && bit_en && rx_enable;
   assign ext_ok = !ext_sync_n && !mode_bop;

   sfd_shift #(.W(W), .CW(CW)) u_shift (
      .clk(clk), .rst_n(rst_n), .en_rx(rx_enable), .bit_en(bit_en),
      .rx_bit(rx_bit), .win_nxt(win_nxt), .fill_nxt(fill_nxt)
   );

   sfd_match #(.W(W), .SHORT_W(SHORT_W), .CW(CW), .FLAG(FLAG)) u_match (
      .win(win_nxt), .fill(fill_nxt), .len(len), .bop(mode_bop),
      .short_sel(sync_short), .pattern(sync_char), .hit(raw_hit)
   );

   sfd_frame #(.CW(CW)) u_frame (
      .clk(clk), .rst_n(rst_n), .en_rx(rx_enable), .hunt(hunt),
      .bit_en(bit_en), .start(hit || ext_ok), .len(len),
      .locked(locked), .strobe(char_strobe)
   );

   sfd_detect u_detect (
      .clk(clk), .rst_n(rst_n), .en_rx(rx_enable), .bit_en(bit_en),
      .hit(hit), .pin_as_rts(pin_as_rts), .rts_req(rts_req),
      .det_n(sync_det_n)
   );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_enable,
   input logic bit_en,
   input logic mode_bop,
   input logic ext_sync_n,
   input logic hunt,
   input logic pin_as_rts,
   input logic sync_det_n,
   input logic char_strobe,
   input logic locked
);
   p_det_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_as_rts && $past(!pin_as_rts) && $fell(sync_det_n)) |-> $past(bit_en));

   p_det_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && $past(rx_enable) && !pin_as_rts && $past(!pin_as_rts) && !$past(bit_en))
         |-> $stable(sync_det_n));

   p_strobe_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      char_strobe |-> $past(locked));

   p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      char_strobe |=> !char_strobe);

   p_ext_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && !hunt && bit_en && !mode_bop && !ext_sync_n) |=> locked);

   p_hunt_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hunt |=> !locked);

   p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (!locked && !char_strobe));
endmodule

bind sync_flag_detect sfd_checker u_sfd_checker (
   .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_en(bit_en),
   .mode_bop(mode_bop), .ext_sync_n(ext_sync_n), .hunt(hunt),
   .pin_as_rts(pin_as_rts), .sync_det_n(sync_det_n),
   .char_strobe(char_strobe), .locked(locked)
);

// File: tb/tb_sync_flag_detect.sv
module tb_sync_flag_detect;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {bop, short, sync[7:0], nbits[4:0], stream[15:0] (bit i sent i-th), det mask[15:0]}
   localparam logic [46:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'h16, 5'd12, 16'h0DA3, 16'h0400},
      {1'b1, 1'b0, 8'h16, 5'd12, 16'h0BF7, 16'h0800},
      {1'b0, 1'b1, 8'hE5, 5'd10, 16'h00A4, 16'h0100},
      {1'b1, 1'b0, 8'h00, 5'd10, 16'h03BF, 16'h0000},
      {1'b1, 1'b0, 8'h00, 5'd16, 16'hBF7E, 16'h8100},
      {1'b0, 1'b0, 8'h16, 5'd12, 16'h0BF7, 16'h0000}
   };

   logic clk = 1'b0;
   logic rst_n, rx_enable, bit_en, rx_bit, mode_bop, sync_short;
   logic [7:0] sync_char;
   logic ext_sync_n, hunt, pin_as_rts, rts_req;
   logic sync_det_n, char_strobe, locked;
   logic last_strobe;
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_flag_detect dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_en(bit_en),
      .rx_bit(rx_bit), .mode_bop(mode_bop), .sync_short(sync_short),
      .sync_char(sync_char), .ext_sync_n(ext_sync_n), .hunt(hunt),
      .pin_as_rts(pin_as_rts), .rts_req(rts_req), .sync_det_n(sync_det_n),
      .char_strobe(char_strobe), .locked(locked)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_bit = b; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0; last_strobe = char_strobe;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] c, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(c[i]);
   endtask

   task automatic restart();
      @(negedge clk); rx_enable = 1'b0;
      @(negedge clk); rx_enable = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      logic [16:0] smask;
      logic [15:0] obs;
      bit det_seen;
      rst_n = 1'b0; rx_enable = 1'b0; bit_en = 1'b0; rx_bit = 1'b0;
      mode_bop = 1'b0; sync_short = 1'b0; sync_char = 8'h16;
      ext_sync_n = 1'b1; hunt = 1'b0; pin_as_rts = 1'b0; rts_req = 1'b0;
      last_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sync_det_n == 1'b1, "R1 det_n", int'(sync_det_n), 1);
      chk(char_strobe == 1'b0, "R1 strobe", int'(char_strobe), 0);
      chk(locked == 1'b0, "R1 locked", int'(locked), 0);

      // Vector walk: R2/R3/R4/R5 detect positions
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk); rx_enable = 1'b0;
         mode_bop = VEC[v][46]; sync_short = VEC[v][45]; sync_char = VEC[v][44:37];
         @(negedge clk); rx_enable = 1'b1;
         obs = '0;
         for (int i = 0; i < int'(VEC[v][36:32]); i++) begin
            send_bit(VEC[v][16 + i]);
            if (!sync_det_n) obs[i] = 1'b1;
         end
         chk(obs == VEC[v][15:0], "R2/R3/R4/R5 vector", int'(obs), int'(VEC[v][15:0]));
      end

      // R6 8-bit framing and strobe period, R4 pulse width
      mode_bop = 1'b0; sync_short = 1'b0; sync_char = 8'h16;
      restart();
      send_bit(1'b1);
      chk(locked == 1'b0, "R6 unlocked before match", int'(locked), 0);
      send_char(8'h16, 8);
      chk(locked == 1'b1, "R6 locked at match", int'(locked), 1);
      smask = '0;
      for (int i = 1; i <= 16; i++) begin
         send_bit(1'b1);
         if (last_strobe) smask[i] = 1'b1;
         if (i == 1) chk(sync_det_n == 1'b0, "R4 det low one bit later", int'(sync_det_n), 0);
         if (i == 2) chk(sync_det_n == 1'b1, "R4 det width one bit", int'(sync_det_n), 1);
      end
      chk(smask == 17'h10100, "R6 strobe every 8", int'(smask), 'h10100);

      // R6 / R2 6-bit framing
      sync_short = 1'b1; sync_char = 8'hE5;
      restart();
      send_char(8'h25, 6);
      chk(locked == 1'b1, "R2 6-bit lock", int'(locked), 1);
      smask = '0;
      for (int i = 1; i <= 12; i++) begin
         send_bit(1'b1);
         if (last_strobe) smask[i] = 1'b1;
      end
      chk(smask == 17'h01040, "R6 strobe every 6", int'(smask), 'h1040);

      // R7 external sync in character mode
      sync_short = 1'b0; sync_char = 8'h16;
      restart();
      ext_sync_n = 1'b0; send_bit(1'b1); ext_sync_n = 1'b1;
      chk(locked == 1'b1, "R7 ext lock", int'(locked), 1);
      smask = '0; det_seen = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         send_bit(1'b1);
         if (last_strobe) smask[i] = 1'b1;
         if (!sync_det_n) det_seen = 1'b1;
      end
      chk(smask == 17'h00100, "R7 ext strobe", int'(smask), 'h100);
      chk(det_seen == 1'b0, "R7 ext no detect", int'(det_seen), 0);

      // R7 external sync ignored in bit-oriented mode
      mode_bop = 1'b1;
      restart();
      ext_sync_n = 1'b0;
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      ext_sync_n = 1'b1;
      chk(locked == 1'b0, "R7 ext ignored bop", int'(locked), 0);

      // R8 hunt command
      mode_bop = 1'b0;
      restart();
      ext_sync_n = 1'b0; send_bit(1'b1); ext_sync_n = 1'b1;
      @(negedge clk); hunt = 1'b1;
      @(negedge clk); hunt = 1'b0;
      chk(locked == 1'b0, "R8 hunt unlocks", int'(locked), 0);
      smask = '0;
      for (int i = 1; i <= 10; i++) begin
         send_bit(1'b1);
         if (last_strobe) smask[i] = 1'b1;
      end
      chk(smask == '0, "R8 no strobes while hunting", int'(smask), 0);
      send_char(8'h16, 8);
      chk(locked == 1'b1, "R8 relock", int'(locked), 1);

      // R9 disable clears pending detect and lock
      restart();
      send_char(8'h16, 8);
      restart();
      chk(locked == 1'b0, "R9 lock cleared", int'(locked), 0);
      send_bit(1'b1);
      chk(sync_det_n == 1'b1, "R9 pending detect cleared", int'(sync_det_n), 1);

      // R10 pin used as request-to-send
      restart();
      @(negedge clk); pin_as_rts = 1'b1; rts_req = 1'b1;
      @(negedge clk);
      chk(sync_det_n == 1'b0, "R10 rts asserted", int'(sync_det_n), 0);
      rts_req = 1'b0;
      send_char(8'h16, 8);
      send_bit(1'b1);
      chk(sync_det_n == 1'b1, "R10 detect hidden", int'(sync_det_n), 1);
      chk(locked == 1'b1, "R10 framing continues", int'(locked), 1);
      pin_as_rts = 1'b0;
      @(negedge clk);
      chk(sync_det_n == 1'b0, "R10 detect shown again", int'(sync_det_n), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule